// File: doc/BRIEF.md
# Memory Region Protection Checker

This block guards a multi-port memory controller. It holds a table of twenty access rules. For every transaction it is shown, it decides whether the transaction is accepted or rejected. A transaction is described by its port number, transaction ID, byte address and a secure/non-secure attribute. A rule hits when four things are all true:

- its address window (1 MiB granular, both bounds inclusive) covers the address;
- its ID range covers the ID;
- its port mask contains the port;
- its security field admits the attribute.

The lowest-numbered hitting rule supplies the outcome. When no rule hits, a per-port default bit decides.

Software never writes a rule directly. It fills three staging registers (address bounds, ID bounds, rule data) and then writes a command register. The command either copies the staging registers into a chosen rule or loads a chosen rule back into them for readback. The decision is registered, so it appears one clock after the request.

Top module: `mem_guard`

## Requirements
- R1: After reset every rule is invalid, all configuration registers read 0, `dec_valid` is low, and any transaction is accepted (`dec_reject`=0).
- R2: The config registers are selected by `cfg_sel`:
  - 0 is the command register. Bits [4:0] hold the rule number and read back. Writing bit 5 commits the staging registers into that rule. Writing bit 6 alone loads that rule into the staging registers.
  - 1 holds the address bounds: low [11:0], high [23:12].
  - 2 holds the ID bounds: low [11:0], high [23:12].
  - 3 holds the rule data: security [1:0], valid [2], port mask [12:3], result [13].
  - 4 holds the default, one bit per port in [9:0].
- R3: A rule's address window matches when address bits [31:20] lie between the low and high bound, both inclusive.
- R4: A rule's ID range matches when the transaction ID lies between the low and high ID, both inclusive.
- R5: A rule matches only ports whose mask bit is set. A port number of 10 or more never hits any rule and is always rejected.
- R6: Security bit 0 admits secure transactions (`txn_secure`=1) and bit 1 admits non-secure ones.
- R7: A rule whose valid bit is 0 never hits.
- R8: When several rules hit, the lowest-numbered one decides: result 0 accepts, result 1 rejects.
- R9: When no rule hits, default bit p decides for port p: 0 accepts, 1 rejects.
- R10: `dec_valid` and `dec_reject` update one clock after `txn_valid` is sampled. `dec_valid` is low in any cycle following one with no request.
- R11: A commit or load naming a rule number of 20 or more changes nothing. A committed rule is used by every transaction sampled after the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected register contents |
| txn_valid | input | 1 | Transaction request present |
| txn_port | input | 4 | Requesting port number |
| txn_id | input | 12 | Transaction ID |
| txn_addr | input | 32 | Transaction byte address |
| txn_secure | input | 1 | 1 = secure transaction |
| dec_valid | output | 1 | Decision present |
| dec_reject | output | 1 | 1 = reject, 0 = accept |

## Verification
The bench probes the exact edges of both windows: the first and last MiB of a region and the lowest and highest ID. An off-by-one comparator would flip the outcome there. It overlaps an accepting low-numbered rule with a rejecting higher-numbered one. A design with the priority reversed would reject transactions that should pass. It drives the wrong security attribute, a port absent from a mask, and an out-of-range port number. These show whether the design leaks to a rule or indexes past the default register. It also commits to rule 20 and clears valid bits. A table that wrapped the index, or that honoured invalid rules, would then accept traffic that must be refused.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;
    parameter int NUM_RULES = 20;
    parameter int NUM_PORTS = 10;
    parameter int BOUND_W   = 12;
    parameter int ID_W      = 12;
    parameter int ADDR_W    = 32;
    parameter int CFG_W     = 32;
    parameter int SEC_W     = 2;

    localparam int PORT_W     = $clog2(NUM_PORTS);
    localparam int RSEL_W     = $clog2(NUM_RULES);
    localparam int CMD_COMMIT = RSEL_W;
    localparam int CMD_LOAD   = RSEL_W + 1;
    localparam int VALID_BIT  = SEC_W;
    localparam int PMASK_LSB  = SEC_W + 1;
    localparam int RESULT_BIT = PMASK_LSB + NUM_PORTS;
    localparam int DATA_W     = RESULT_BIT + 1;

    localparam logic [2:0] SEL_CMD  = 3'd0;
    localparam logic [2:0] SEL_ADDR = 3'd1;
    localparam logic [2:0] SEL_ID   = 3'd2;
    localparam logic [2:0] SEL_DATA = 3'd3;
    localparam logic [2:0] SEL_DFLT = 3'd4;

    typedef struct packed {
        logic [BOUND_W-1:0]   addr_hi;
        logic [BOUND_W-1:0]   addr_lo;
        logic [ID_W-1:0]      id_hi;
        logic [ID_W-1:0]      id_lo;
        logic                 result;
        logic [NUM_PORTS-1:0] ports;
        logic                 valid;
        logic [SEC_W-1:0]     sec;
    } rule_t;

    function automatic rule_t stage_to_rule(
        input logic [2*BOUND_W-1:0] a,
        input logic [2*ID_W-1:0]    i,
        input logic [DATA_W-1:0]    d
    );
        rule_t r;
        r.addr_lo = a[BOUND_W-1:0];
        r.addr_hi = a[2*BOUND_W-1:BOUND_W];
        r.id_lo   = i[ID_W-1:0];
        r.id_hi   = i[2*ID_W-1:ID_W];
        r.sec     = d[SEC_W-1:0];
        r.valid   = d[VALID_BIT];
        r.ports   = d[PMASK_LSB +: NUM_PORTS];
        r.result  = d[RESULT_BIT];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] rule_to_data(input rule_t r);
        return {r.result, r.ports, r.valid, r.sec};
    endfunction
endpackage

// File: rtl/mem_guard_regs.sv
module mem_guard_regs
    import mem_guard_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [2:0]                  cfg_sel,
    input  logic [CFG_W-1:0]            cfg_wdata,
    output logic [CFG_W-1:0]            cfg_rdata,
    output rule_t [NUM_RULES-1:0]       rules_o,
    output logic [NUM_PORTS-1:0]        dflt_o
);
    typedef struct packed {
        logic [RSEL_W-1:0]      rsel;
        logic [2*BOUND_W-1:0]   st_addr;
        logic [2*ID_W-1:0]      st_id;
        logic [DATA_W-1:0]      st_data;
        logic [NUM_PORTS-1:0]   dflt;
        rule_t [NUM_RULES-1:0]  rules;
    } regs_t;

    regs_t q, d;
    logic [RSEL_W-1:0] tgt;
    logic unused_wdata;

    assign unused_wdata = ^cfg_wdata[CFG_W-1:CMD_LOAD+1];
    assign tgt = cfg_wdata[RSEL_W-1:0];

    always_comb begin
        d = q;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_CMD: begin
                    d.rsel = tgt;
                    for (int r = 0; r < NUM_RULES; r++) begin
                        if (tgt == RSEL_W'(r)) begin
                            if (cfg_wdata[CMD_COMMIT]) begin
                                d.rules[r] = stage_to_rule(q.st_addr, q.st_id, q.st_data);
                            end else if (cfg_wdata[CMD_LOAD]) begin
                                d.st_addr = {q.rules[r].addr_hi, q.rules[r].addr_lo};
                                d.st_id   = {q.rules[r].id_hi, q.rules[r].id_lo};
                                d.st_data = rule_to_data(q.rules[r]);
                            end
                        end
                    end
                end
                SEL_ADDR: d.st_addr = cfg_wdata[2*BOUND_W-1:0];
                SEL_ID:   d.st_id   = cfg_wdata[2*ID_W-1:0];
                SEL_DATA: d.st_data = cfg_wdata[DATA_W-1:0];
                SEL_DFLT: d.dflt    = cfg_wdata[NUM_PORTS-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_CMD:  cfg_rdata[RSEL_W-1:0]    = q.rsel;
            SEL_ADDR: cfg_rdata[2*BOUND_W-1:0] = q.st_addr;
            SEL_ID:   cfg_rdata[2*ID_W-1:0]    = q.st_id;
            SEL_DATA: cfg_rdata[DATA_W-1:0]    = q.st_data;
            SEL_DFLT: cfg_rdata[NUM_PORTS-1:0] = q.dflt;
            default:  cfg_rdata = '0;
        endcase
    end

    assign rules_o = q.rules;
    assign dflt_o  = q.dflt;
endmodule

// File: rtl/mem_guard_rule_match.sv
module mem_guard_rule_match
    import mem_guard_pkg::*;
(
    input  rule_t              rule_i,
    input  logic [PORT_W-1:0]  port_i,
    input  logic [ID_W-1:0]    id_i,
    input  logic [BOUND_W-1:0] mib_i,
    input  logic               secure_i,
    output logic               hit_o
);
    logic addr_ok, id_ok, port_ok, sec_ok;

    always_comb begin
        addr_ok = (mib_i >= rule_i.addr_lo) && (mib_i <= rule_i.addr_hi);
        id_ok   = (id_i >= rule_i.id_lo) && (id_i <= rule_i.id_hi);
        sec_ok  = secure_i ? rule_i.sec[0] : rule_i.sec[1];
        port_ok = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_i == PORT_W'(p)) port_ok = rule_i.ports[p];
        end
        hit_o = rule_i.valid && addr_ok && id_ok && port_ok && sec_ok;
    end
endmodule

// File: rtl/mem_guard_decide.sv
module mem_guard_decide
    import mem_guard_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 txn_valid,
    input  logic [PORT_W-1:0]    txn_port,
    input  logic [NUM_RULES-1:0] hits,
    input  logic [NUM_RULES-1:0] results,
    input  logic [NUM_PORTS-1:0] dflt,
    output logic                 dec_valid,
    output logic                 dec_reject
);
    typedef struct packed {
        logic vld;
        logic rej;
    } dec_t;

    dec_t q, d;
    logic any_hit, hit_res, port_dflt;

    always_comb begin
        any_hit = 1'b0;
        hit_res = 1'b0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                hit_res = results[i];
            end
        end
        port_dflt = 1'b1;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (txn_port == PORT_W'(p)) port_dflt = dflt[p];
        end
        d.vld = txn_valid;
        d.rej = txn_valid ? (any_hit ? hit_res : port_dflt) : q.rej;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dec_valid  = q.vld;
    assign dec_reject = q.rej;
endmodule

// File: rtl/mem_guard.sv
module mem_guard
    import mem_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              txn_valid,
    input  logic [3:0]        txn_port,
    input  logic [11:0]       txn_id,
    input  logic [31:0]       txn_addr,
    input  logic              txn_secure,
    output logic              dec_valid,
    output logic              dec_reject
);
    rule_t [NUM_RULES-1:0] rules;
    logic  [NUM_PORTS-1:0] dflt;
    logic  [NUM_RULES-1:0] hits;
    logic  [NUM_RULES-1:0] results;
    logic  [BOUND_W-1:0]   mib;
    logic                  unused_addr_lo;

    assign mib            = txn_addr[ADDR_W-1:ADDR_W-BOUND_W];
    assign unused_addr_lo = ^txn_addr[ADDR_W-BOUND_W-1:0];

    mem_guard_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .rules_o   (rules),
        .dflt_o    (dflt)
    );

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        mem_guard_rule_match u_match (
            .rule_i   (rules[g]),
            .port_i   (txn_port),
            .id_i     (txn_id),
            .mib_i    (mib),
            .secure_i (txn_secure),
            .hit_o    (hits[g])
        );
        assign results[g] = rules[g].result;
    end

    mem_guard_decide u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_valid  (txn_valid),
        .txn_port   (txn_port),
        .hits       (hits),
        .results    (results),
        .dflt       (dflt),
        .dec_valid  (dec_valid),
        .dec_reject (dec_reject)
    );
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk
    import mem_guard_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic                  txn_valid,
    input logic [3:0]            txn_port,
    input logic                  dec_valid,
    input logic                  dec_reject,
    input rule_t [NUM_RULES-1:0] rules,
    input logic [NUM_PORTS-1:0]  dflt
);
    assert_req_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> dec_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> !dec_valid);

    assert_bad_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && (txn_port >= 4'(NUM_PORTS))) |=> dec_reject);

    assert_table_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(rules));

    assert_dflt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(dflt));
endmodule

bind mem_guard mem_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .txn_valid  (txn_valid),
    .txn_port   (txn_port),
    .dec_valid  (dec_valid),
    .dec_reject (dec_reject),
    .rules      (rules),
    .dflt       (dflt)
);

// File: tb/mem_guard_bench.sv
module mem_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        txn_valid = 1'b0;
    logic [3:0]  txn_port = '0;
    logic [11:0] txn_id = '0;
    logic [31:0] txn_addr = '0;
    logic        txn_secure = 1'b0;
    logic        dec_valid, dec_reject;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mem_guard u_mem_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_valid(txn_valid),
        .txn_port(txn_port), .txn_id(txn_id), .txn_addr(txn_addr),
        .txn_secure(txn_secure), .dec_valid(dec_valid), .dec_reject(dec_reject)
    );

    // vector: {port[3:0], id[11:0], addr[31:0], secure, expected reject}
    localparam int NV = 14;
    localparam logic [49:0] VECS [NV] = '{
        {4'd1,  12'h005, 32'h0000_1000, 1'b1, 1'b0}, // R3 rule 0 window
        {4'd0,  12'h010, 32'h1000_0000, 1'b1, 1'b0}, // R4 low id edge, R8 rule 1 over rule 2
        {4'd0,  12'h020, 32'h1FFF_FFFC, 1'b1, 1'b0}, // R3 R4 inclusive high edges
        {4'd0,  12'h021, 32'h1000_0000, 1'b1, 1'b1}, // R4 id past range -> rule 2 rejects
        {4'd1,  12'h015, 32'h1000_0000, 1'b1, 1'b1}, // R5 port not in rule 1 mask
        {4'd2,  12'h015, 32'h1800_0000, 1'b0, 1'b1}, // R6 non-secure refused by rule 1
        {4'd2,  12'h015, 32'h1800_0000, 1'b1, 1'b0}, // R6 secure admitted
        {4'd9,  12'h000, 32'h3000_0000, 1'b0, 1'b0}, // R6 rule 19 non-secure only
        {4'd9,  12'h000, 32'h3000_0000, 1'b1, 1'b1}, // R9 secure misses, default rejects
        {4'd9,  12'h000, 32'h3010_0000, 1'b0, 1'b1}, // R3 one MiB past single-MiB window
        {4'd3,  12'h000, 32'h3010_0000, 1'b0, 1'b0}, // R9 port 3 default accepts
        {4'd3,  12'h007, 32'h2FFF_FFFF, 1'b1, 1'b0}, // R9 gap between rules
        {4'd4,  12'h007, 32'h2000_0000, 1'b1, 1'b1}, // R9 port 4 default rejects
        {4'd10, 12'h000, 32'h0000_0000, 1'b1, 1'b1}  // R5 out-of-range port
    };

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        n_chk++;
        if (cfg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s reg %0d: got %h expected %h", req, sel, cfg_rdata, exp);
        end
    endtask

    task automatic txn(input logic [3:0] p, input logic [11:0] id, input logic [31:0] a,
                       input logic s, input logic exp, input string req);
        @(negedge clk);
        txn_valid = 1'b1; txn_port = p; txn_id = id; txn_addr = a; txn_secure = s;
        @(negedge clk);
        txn_valid = 1'b0;
        n_chk++;
        if (dec_valid !== 1'b1 || dec_reject !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid=%b reject=%b expected valid=1 reject=%b",
                     req, dec_valid, dec_reject, exp);
        end
    endtask

    task automatic put_rule(input int num, input logic [31:0] a, input logic [31:0] i,
                            input logic [31:0] dt);
        wr(3'd1, a);
        wr(3'd2, i);
        wr(3'd3, dt);
        wr(3'd0, 32'(num) | 32'h20);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        n_chk++;
        if (dec_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 dec_valid: got %b expected 0", dec_valid);
        end
        for (int s = 0; s < 5; s++) rd_check(3'(s), 32'h0, "R1");
        txn(4'd5, 12'h123, 32'h8000_0000, 1'b0, 1'b0, "R1 accept all after reset");

        // program table: data = sec | valid<<2 | ports<<3 | result<<13
        put_rule(0,  32'h0FF000, 32'hFFF000, 32'h1FFF);
        put_rule(1,  32'h1FF100, 32'h020010, 32'h002D);
        put_rule(2,  32'h1FF100, 32'hFFF000, 32'h3FFF);
        put_rule(19, 32'h300300, 32'hFFF000, 32'h1006);
        wr(3'd4, 32'h3F7);
        rd_check(3'd4, 32'h3F7, "R2 default readback");

        for (int v = 0; v < NV; v++) begin
            txn(VECS[v][49:46], VECS[v][45:34], VECS[v][33:2], VECS[v][1], VECS[v][0],
                $sformatf("R8 table vector %0d", v));
        end

        // R2 load rule 1 back into staging
        wr(3'd0, 32'h41);
        rd_check(3'd1, 32'h1FF100, "R2 addr readback");
        rd_check(3'd2, 32'h020010, "R2 id readback");
        rd_check(3'd3, 32'h00002D, "R2 data readback");
        rd_check(3'd0, 32'h1, "R2 rule number readback");

        // R11 commit to rule 20 ignored
        put_rule(20, 32'hFFF000, 32'hFFF000, 32'h1FFF);
        txn(4'd4, 12'h007, 32'h2000_0000, 1'b1, 1'b1, "R11 commit to rule 20 ignored");
        wr(3'd0, 32'h54);
        rd_check(3'd1, 32'hFFF000, "R11 load from rule 20 ignored");
        // R11 new rule effective at once
        wr(3'd0, 32'h25);
        txn(4'd4, 12'h007, 32'h2000_0000, 1'b1, 1'b0, "R11 rule 5 takes effect");

        // R7 clear valid in rules 0 and 5
        wr(3'd3, 32'h1FFB);
        wr(3'd0, 32'h20);
        wr(3'd0, 32'h25);
        txn(4'd1, 12'h005, 32'h0000_1000, 1'b1, 1'b1, "R7 invalid rule ignored");
        txn(4'd4, 12'h007, 32'h2000_0000, 1'b1, 1'b1, "R7 invalid rule 5 ignored");

        // R10 no request -> dec_valid low
        @(negedge clk);
        n_chk++;
        if (dec_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 idle: got %b expected 0", dec_valid);
        end

        // R9 default all-accept
        wr(3'd4, 32'h0);
        txn(4'd4, 12'h007, 32'h2000_0000, 1'b1, 1'b0, "R9 zero default accepts");
        txn(4'd10, 12'h000, 32'h0000_0000, 1'b1, 1'b1, "R5 bad port still rejected");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule